// File: doc/BRIEF.md
# Print Plane Video Line Controller

This block feeds one colour plane of a page to a print engine, one raster line at a time. Decoded 16-bit image words are pushed into an internal line FIFO. The block compares the FIFO fill level against a programmed line length in words. When the level first reaches that length, it raises a sticky ready flag. Software answers the flag with a start pulse. The block then waits for the engine's page sync, counts line syncs down the page and shifts pixels out serially. Output happens only inside a rectangle set by a top margin, a printed line count, a left margin and a printed pixel count.

The serial output is one bit per clock. The clock is either supplied by the engine, or generated inside the chip and only loosely related to the engine's sync pulses. An input selects between these two cases. In the loosely related case, the line and page sync inputs pass through a longer synchronizer. When the last pixel of the last printed line leaves the block, an end-of-plane flag is set and the block returns to idle. Running out of data inside the printed window sets a sticky underrun flag, and the missing pixels are printed as blank.

Top module: `plane_video_ctrl`

## Requirements
- R1: The FIFO keeps words in write order and holds at most DEPTH words (a power of two). A write while `fifo_full` is high is dropped. `fifo_level` gives the number of words stored.
- R2: `ready_flag` is set on the clock after `fifo_level` first becomes greater than or equal to a nonzero `line_words`. It stays set until `ready_clr`; a set in the same cycle wins over the clear.
- R3: `irq` is registered one clock after the flags. It is high when (`ready_flag` and `ready_ie`) or (`eop_flag` and `eop_ie`).
- R4: A `start` pulse is accepted only while the block is idle and `ready_flag` is high. Any other start has no effect: no word is read and `video_out` stays 0.
- R5: After an accepted start, the page begins at the next rising edge of `vsync_in`. Each following rising edge of `hsync_in` starts a new line, numbered from 1. Lines `top_margin`+1 through `top_margin`+`print_lines` are printed.
- R6: Within a line, pixel position p counts from 0. Positions `left_margin` to `left_margin`+`print_pixels`-1 are printed. In synchronous mode, pixel p appears on `video_out` after the (p+2)-th rising clock edge following the edge that samples `hsync_in` high.
- R7: Each printed line starts on a fresh FIFO word. One word is read at each 16-pixel boundary of the printed span, and each word is shifted out MSB first. Bits left over in the last word of a line are discarded.
- R8: Outside the printed rectangle `video_out` is 0 and no FIFO word is read.
- R9: If the FIFO is empty at a word boundary inside the printed span, the next 16 pixel slots are output as 0. `underrun_flag` is then set and stays set until `urun_clr`.
- R10: `eop_flag` is set on the same clock edge that outputs the last pixel of the last printed line. The block then returns to idle and needs a new start. The flag is cleared by `eop_clr`.
- R11: With `async_mode` high, both sync inputs pass through a two-stage synchronizer. This adds one clock of latency to every timing in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one image word |
| wr_data | input | WORD_W | Image word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_level | output | CW | Words stored |
| line_words | input | CW | Ready threshold in words |
| top_margin | input | LW | Blank lines before the printed area |
| print_lines | input | LW | Printed lines |
| left_margin | input | PW | Blank pixels before the printed span |
| print_pixels | input | PW | Printed pixels per line |
| async_mode | input | 1 | Select the two-stage sync path |
| hsync_in | input | 1 | Engine line sync, active high |
| vsync_in | input | 1 | Engine page sync, active high |
| start | input | 1 | Start command pulse |
| ready_clr | input | 1 | Clear ready flag |
| eop_clr | input | 1 | Clear end-of-plane flag |
| urun_clr | input | 1 | Clear underrun flag |
| ready_ie | input | 1 | Ready interrupt enable |
| eop_ie | input | 1 | End-of-plane interrupt enable |
| video_out | output | 1 | Serial pixel output |
| ready_flag | output | 1 | Line-ready flag |
| eop_flag | output | 1 | End-of-plane flag |
| underrun_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A fixed directed page tests the threshold crossing, the interrupt delay and the counts along both axes. Its 40-pixel width ends in a partly used word. Random pages vary the margins, widths and line counts, which separates errors in the window compare from errors in word boundary handling. Other patterns exercise the remaining paths:
- A start given before the threshold is reached must be ignored.
- A page fed one word short must show the underrun path.
- An asynchronous page must show exactly one extra clock of latency.
- An overfilled FIFO must give back exactly its first DEPTH words in order.

// File: rtl/pplv_pkg.sv
package pplv_pkg;
  typedef enum logic [1:0] {
    PV_IDLE  = 2'd0,
    PV_ARMED = 2'd1,
    PV_PAGE  = 2'd2
  } pv_state_e;
endpackage

// File: rtl/pplv_sync_edge.sv
module pplv_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_mode,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES-1:0] st;
  logic              sel;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= 1'b0;
        else     st[0] <= sig_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= 1'b0;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign sel  = async_mode ? st[STAGES-1] : st[0];
  assign rise = sel & ~prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sel;
  end
endmodule

// File: rtl/pplv_line_fifo.sv
module pplv_line_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  output logic              empty,
  output logic              full,
  output logic [WORD_W-1:0] q,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr, rd_next;
  logic [CW-1:0]     count;
  logic              do_wr, do_rd;

  assign do_wr   = wr_en & (count != DEPTH_C);
  assign do_rd   = pop & (count != '0);
  assign rd_next = do_rd ? rd_ptr + AW'(1) : rd_ptr;

  // Read-ahead port: q always shows the word at the head of the queue.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
    if (do_wr && (wr_ptr == rd_next)) q <= wr_data;
    else                              q <= mem[rd_next];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_next;
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign empty = (count == '0);
  assign full  = (count == DEPTH_C);
  assign level = count;

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);
  assert_level_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !pop) |=> $stable(count));
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/pplv_raster.sv
module pplv_raster import pplv_pkg::*; #(
  parameter int LW = 14,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          vs_rise,
  input  logic          hs_rise,
  input  logic [LW-1:0] top_m,
  input  logic [LW-1:0] n_lines,
  input  logic [PW-1:0] left_m,
  input  logic [PW-1:0] n_pix,
  output logic          px_act,
  output logic          line_start,
  output logic          last_px,
  output logic          idle
);
  pv_state_e     st;
  logic [LW-1:0] vline;
  logic          line_on, in_line;
  logic [PW-1:0] hpos;

  logic [LW:0] vnext, vlim;
  logic [PW:0] hpos_x, hend;

  assign vnext  = {1'b0, vline} + (LW+1)'(1);
  assign vlim   = {1'b0, top_m} + {1'b0, n_lines};
  assign hpos_x = {1'b0, hpos};
  assign hend   = {1'b0, left_m} + {1'b0, n_pix};

  assign px_act = (st == PV_PAGE) & in_line & line_on &
                  (hpos_x >= {1'b0, left_m}) & (hpos_x < hend);
  assign last_px    = px_act & (hpos_x + (PW+1)'(1) == hend) & ({1'b0, vline} == vlim);
  assign line_start = (st == PV_PAGE) & hs_rise;
  assign idle       = (st == PV_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PV_IDLE;
      vline   <= '0;
      line_on <= 1'b0;
      in_line <= 1'b0;
      hpos    <= '0;
    end else begin
      case (st)
        PV_IDLE: if (arm) st <= PV_ARMED;
        PV_ARMED: if (vs_rise) begin
          st      <= PV_PAGE;
          vline   <= '0;
          line_on <= 1'b0;
          in_line <= 1'b0;
        end
        PV_PAGE: begin
          if (last_px) begin
            st      <= PV_IDLE;
            in_line <= 1'b0;
          end else if (hs_rise) begin
            vline   <= vnext[LW-1:0];
            line_on <= (vnext > {1'b0, top_m}) && (vnext <= vlim);
            in_line <= 1'b1;
            hpos    <= '0;
          end else if (in_line) begin
            if (hpos_x + (PW+1)'(1) >= hend) in_line <= 1'b0;
            else                             hpos    <= hpos + PW'(1);
          end
        end
        default: st <= PV_IDLE;
      endcase
    end
  end

  assert_wait_page_R5: assert property (@(posedge clk) disable iff (rst)
    (st == PV_ARMED && !vs_rise) |=> (st == PV_ARMED));
  assert_line_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (line_start && !last_px) |=> (hpos == '0) && in_line);
  assert_eop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    last_px |=> (st == PV_IDLE) && !px_act);
endmodule

// File: rtl/pplv_serializer.sv
module pplv_serializer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              px_act,
  input  logic              line_start,
  input  logic              empty,
  input  logic [WORD_W-1:0] q,
  output logic              pop,
  output logic              urun_set,
  output logic              video
);
  localparam int BW = $clog2(WORD_W);

  logic [BW-1:0]     bitcnt;
  logic [WORD_W-1:0] sh;
  logic              slot;

  assign slot     = px_act & ~line_start & (bitcnt == '0);
  assign pop      = slot & ~empty;
  assign urun_set = slot & empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt <= '0;
      sh     <= '0;
      video  <= 1'b0;
    end else if (line_start) begin
      bitcnt <= '0;
      video  <= 1'b0;
    end else if (px_act) begin
      bitcnt <= bitcnt + BW'(1);
      if (bitcnt == '0) begin
        if (!empty) begin
          video <= q[WORD_W-1];
          sh    <= q << 1;
        end else begin
          video <= 1'b0;
          sh    <= '0;
        end
      end else begin
        video <= sh[WORD_W-1];
        sh    <= sh << 1;
      end
    end else begin
      video <= 1'b0;
    end
  end

  assert_dark_outside_R8: assert property (@(posedge clk) disable iff (rst)
    !px_act |=> !video);
  assert_underrun_dark_R9: assert property (@(posedge clk) disable iff (rst)
    urun_set |=> !video);
endmodule

// File: rtl/plane_video_ctrl.sv
module plane_video_ctrl import pplv_pkg::*; #(
  parameter int WORD_W      = 16,
  parameter int DEPTH       = 512,
  parameter int LW          = 14,
  parameter int PW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_data,
  output logic                       fifo_full,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input  logic [$clog2(DEPTH+1)-1:0] line_words,
  input  logic [LW-1:0]              top_margin,
  input  logic [LW-1:0]              print_lines,
  input  logic [PW-1:0]              left_margin,
  input  logic [PW-1:0]              print_pixels,
  input  logic                       async_mode,
  input  logic                       hsync_in,
  input  logic                       vsync_in,
  input  logic                       start,
  input  logic                       ready_clr,
  input  logic                       eop_clr,
  input  logic                       urun_clr,
  input  logic                       ready_ie,
  input  logic                       eop_ie,
  output logic                       video_out,
  output logic                       ready_flag,
  output logic                       eop_flag,
  output logic                       underrun_flag,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic              hs_rise, vs_rise;
  logic              pop, empty;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     level;
  logic              px_act, line_start, last_px, idle;
  logic              urun_set, arm;
  logic              full_line, full_prev;

  pplv_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst(rst), .async_mode(async_mode), .sig_in(hsync_in), .rise(hs_rise));
  pplv_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst(rst), .async_mode(async_mode), .sig_in(vsync_in), .rise(vs_rise));

  pplv_line_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .empty(empty), .full(fifo_full), .q(head), .level(level));

  pplv_raster #(.LW(LW), .PW(PW)) u_ras (
    .clk(clk), .rst(rst), .arm(arm), .vs_rise(vs_rise), .hs_rise(hs_rise),
    .top_m(top_margin), .n_lines(print_lines), .left_m(left_margin), .n_pix(print_pixels),
    .px_act(px_act), .line_start(line_start), .last_px(last_px), .idle(idle));

  pplv_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst(rst), .px_act(px_act), .line_start(line_start), .empty(empty),
    .q(head), .pop(pop), .urun_set(urun_set), .video(video_out));

  assign fifo_level = level;
  assign full_line  = (level >= line_words) && (line_words != '0);
  assign arm        = start & ready_flag & idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_prev     <= 1'b0;
      ready_flag    <= 1'b0;
      eop_flag      <= 1'b0;
      underrun_flag <= 1'b0;
      irq           <= 1'b0;
    end else begin
      full_prev <= full_line;
      if (full_line && !full_prev) ready_flag <= 1'b1;
      else if (ready_clr)          ready_flag <= 1'b0;
      if (last_px)      eop_flag <= 1'b1;
      else if (eop_clr) eop_flag <= 1'b0;
      if (urun_set)      underrun_flag <= 1'b1;
      else if (urun_clr) underrun_flag <= 1'b0;
      irq <= (ready_flag & ready_ie) | (eop_flag & eop_ie);
    end
  end

  assert_ready_set_R2: assert property (@(posedge clk) disable iff (rst)
    (full_line && !full_prev) |=> ready_flag);
  assert_eop_flag_R10: assert property (@(posedge clk) disable iff (rst)
    last_px |=> eop_flag);
  assert_urun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (underrun_flag && !urun_clr) |=> underrun_flag);
  assert_start_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && !(start && ready_flag)) |=> idle);
endmodule

// File: tb/plane_video_ctrl_test.sv
module plane_video_ctrl_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH+1);
  localparam int LW    = 8;
  localparam int PW    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic fifo_full;
  logic [CW-1:0] fifo_level;
  logic [CW-1:0] line_words = '0;
  logic [LW-1:0] top_margin = '0, print_lines = '0;
  logic [PW-1:0] left_margin = '0, print_pixels = '0;
  logic async_mode = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0, start = 1'b0;
  logic ready_clr = 1'b0, eop_clr = 1'b0, urun_clr = 1'b0, ready_ie = 1'b0, eop_ie = 1'b0;
  logic video_out, ready_flag, eop_flag, underrun_flag, irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] wq [0:63];
  int wh = 0, wt = 0;
  bit exp_urun;

  always #5 clk = ~clk;

  plane_video_ctrl #(.WORD_W(16), .DEPTH(DEPTH), .LW(LW), .PW(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
    .fifo_level(fifo_level), .line_words(line_words), .top_margin(top_margin),
    .print_lines(print_lines), .left_margin(left_margin), .print_pixels(print_pixels),
    .async_mode(async_mode), .hsync_in(hsync_in), .vsync_in(vsync_in), .start(start),
    .ready_clr(ready_clr), .eop_clr(eop_clr), .urun_clr(urun_clr), .ready_ie(ready_ie),
    .eop_ie(eop_ie), .video_out(video_out), .ready_flag(ready_flag), .eop_flag(eop_flag),
    .underrun_flag(underrun_flag), .irq(irq));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int words_per_line(input int width);
    return (width + 15) / 16;
  endfunction

  task automatic push(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (wt - wh < DEPTH) begin wq[wt % 64] = d; wt++; end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic page_sync();
    vsync_in = 1'b1; @(negedge clk); vsync_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flags();
    ready_clr = 1'b1; eop_clr = 1'b1; urun_clr = 1'b1;
    @(negedge clk);
    ready_clr = 1'b0; eop_clr = 1'b0; urun_clr = 1'b0;
  endtask

  // One line: hsync pulse, then compare video_out with the model at each sample.
  task automatic run_line(input int n, input int top, input int lines, input int left,
                          input int width, input int d, input int period);
    bit printed = (n > top) && (n <= top + lines);
    bit last = (n == top + lines);
    int bad = 0, bad_k = -1, bad_a = 0, bad_e = 0;
    logic [15:0] cur = '0;
    hsync_in = 1'b1;
    for (int k = 0; k < period; k++) begin
      int p;
      bit e;
      @(negedge clk);
      if (k == 0) hsync_in = 1'b0;
      p = k - d;
      e = 1'b0;
      if (printed && p >= left && p < left + width) begin
        int r = p - left;
        if (r % 16 == 0) begin
          if (wh < wt) begin cur = wq[wh % 64]; wh++; end
          else begin cur = '0; exp_urun = 1'b1; end
        end
        e = cur[15 - (r % 16)];
      end
      if (video_out !== e) begin
        bad++;
        if (bad_k < 0) begin bad_k = k; bad_a = int'(video_out); bad_e = int'(e); end
      end
      if (last) begin
        if (k == d + left + width - 2)
          check(eop_flag == 1'b0, "R10", "eop before last pixel", int'(eop_flag), 0);
        if (k == d + left + width - 1) begin
          check(eop_flag == 1'b1, "R10", "eop with last pixel", int'(eop_flag), 1);
          check(irq == 1'b0, "R3", "irq one cycle late", int'(irq), 0);
        end
        if (k == d + left + width)
          check(irq == eop_ie, "R3", "irq from eop", int'(irq), int'(eop_ie));
      end
    end
    if (bad != 0) $display("  line %0d first mismatch at sample %0d", n, bad_k);
    check(bad == 0, printed ? "R7" : "R8", printed ? "printed line bits" : "blank line bits",
          bad_a, bad_e);
  endtask

  task automatic run_page(input int top, input int lines, input int left, input int width,
                          input bit amode, input int period);
    int d = amode ? 3 : 2;
    top_margin = LW'(top); print_lines = LW'(lines);
    left_margin = PW'(left); print_pixels = PW'(width);
    async_mode = amode;
    exp_urun = 1'b0;
    check(ready_flag == 1'b1, "R2", "ready before start", int'(ready_flag), 1);
    pulse_start();
    page_sync();
    for (int n = 1; n <= top + lines; n++) run_line(n, top, lines, left, width, d, period);
    check(underrun_flag == exp_urun, "R9", "underrun flag", int'(underrun_flag), int'(exp_urun));
    check(int'(fifo_level) == wt - wh, "R1", "level after page", int'(fifo_level), wt - wh);
    clear_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check(video_out == 1'b0 && ready_flag == 1'b0 && eop_flag == 1'b0, "R4", "reset outputs",
          int'({video_out, ready_flag, eop_flag}), 0);
    check(fifo_level == '0 && irq == 1'b0 && underrun_flag == 1'b0, "R1", "reset level/irq",
          int'(fifo_level), 0);

    // R4: start without ready is ignored
    top_margin = '0; print_lines = LW'(1); left_margin = '0; print_pixels = PW'(16);
    line_words = CW'(3);
    pulse_start();
    page_sync();
    begin
      int lit = 0;
      hsync_in = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (k == 0) hsync_in = 1'b0;
        if (video_out) lit++;
      end
      check(lit == 0, "R4", "video after ignored start", lit, 0);
      check(underrun_flag == 1'b0 && fifo_level == '0, "R4", "no read after ignored start",
            int'(underrun_flag), 0);
    end

    // R2/R3: threshold crossing and interrupt
    ready_ie = 1'b1;
    push(16'hA5C3);
    push(16'h0FF0);
    check(ready_flag == 1'b0, "R2", "ready below threshold", int'(ready_flag), 0);
    push(16'h8001);
    check(ready_flag == 1'b0, "R2", "ready not same edge", int'(ready_flag), 0);
    @(negedge clk);
    check(ready_flag == 1'b1, "R2", "ready after crossing", int'(ready_flag), 1);
    check(irq == 1'b0, "R3", "irq delay", int'(irq), 0);
    @(negedge clk);
    check(irq == 1'b1, "R3", "irq from ready", int'(irq), 1);
    ready_ie = 1'b0;
    for (int i = 0; i < 6; i++) push(16'($urandom));
    check(int'(fifo_level) == 9, "R1", "level count", int'(fifo_level), 9);

    // Directed page: margins on both axes, partial last word
    eop_ie = 1'b1;
    run_page(2, 3, 3, 40, 1'b0, 60);

    // R10: after end of plane, further syncs do nothing
    page_sync();
    begin
      int lit = 0;
      hsync_in = 1'b1;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (k == 0) hsync_in = 1'b0;
        if (video_out) lit++;
      end
      check(lit == 0 && underrun_flag == 1'b0, "R10", "idle after end of plane", lit, 0);
    end

    // R9: one word for a two-word line
    line_words = CW'(1);
    push(16'hF00D);
    @(negedge clk);
    run_page(0, 1, 0, 32, 1'b0, 40);

    // R11: asynchronous sync path
    line_words = CW'(1);
    push(16'h6B29);
    @(negedge clk);
    run_page(0, 1, 1, 16, 1'b1, 30);

    // R5/R6/R7: random geometry
    for (int pg = 0; pg < 8; pg++) begin
      int top = $urandom_range(0, 2);
      int lines = $urandom_range(1, 3);
      int left = $urandom_range(0, 5);
      int width = $urandom_range(1, 48);
      int wpl = words_per_line(width);
      line_words = CW'(wpl);
      eop_ie = pg[0];
      for (int i = 0; i < lines * wpl; i++) push(16'($urandom));
      @(negedge clk);
      run_page(top, lines, left, width, 1'b0, left + width + 8);
    end

    // R1: overfill drops extra writes, order kept
    line_words = CW'(DEPTH);
    for (int i = 0; i < DEPTH + 4; i++) push(16'($urandom));
    check(fifo_full == 1'b1 && int'(fifo_level) == DEPTH, "R1", "full level",
          int'(fifo_level), DEPTH);
    @(negedge clk);
    run_page(0, 1, 0, 16 * DEPTH, 1'b0, 16 * DEPTH + 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule